// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a four-pin serial control link: chip select (`cs_n`), serial clock (`sclk`), serial data in (`sdi`) and a data-out line whose driver enable is brought out as `sdo_oe`, so the pad ring can build the tri-state buffer. Behind the port sit three 8-bit control registers. Their fields go out as individual ports to the rest of the device: interface format, power, soft reset, sample-rate speed, de-emphasis, gain, per-channel inversion, wire mode and input source.

All pins are oversampled in the block's own clock `clk`. Each transaction is one 16-bit frame, sent most significant bit first while chip select is low. A frame that carries the wrong chip address is dropped. A register bit switches the port at run time between read/write operation with a driven data-out and write-only operation in which the data-out pin is released. Writes are refused while the device is powered down or its master clock is reported absent. Power-down also puts every register back to its default value.

Top module: `ctl_serial_port`

## Requirements
- R1: A frame is, in order and MSB first: a 2-bit chip address, a read/write flag, a 5-bit register address and 8 data bits. If the chip address is not the `CHIP_ID` parameter (default 2'b01), the frame writes nothing and `sdo_oe` stays 0.
- R2: A read/write flag of 1 makes the frame a write. A flag of 0 makes it a read, which returns the addressed register on `sdo`.
- R3: Input bits are taken on rising `sclk` edges. Read data changes on falling `sclk` edges: bit 7 appears at the falling edge after the 8th rising edge and bit 0 at the 15th falling edge. With `SYNC_STAGES`=2, a pin change made between `clk` edges shows on the outputs after the third rising `clk` edge.
- R4: A write takes effect at the 16th rising `sclk` edge after chip select falls. If chip select rises before that edge, the frame is dropped and no register changes. Rising edges after the 16th are ignored until chip select goes high.
- R5: While the wire-mode bit is 0, `sdo_oe` is 1 only from the start of read data until chip select rises. At all other times it is 0. `sdo` is 0 whenever `sdo_oe` is 0.
- R6: While the wire-mode bit is 1, read frames are ignored and `sdo_oe` stays 0. Write frames still take effect.
- R7: Writes to register addresses 3 to 31 change nothing. Reads from those addresses return 8'h00.
- R8: Register 0 holds `fmt` in bits 3:2 (default 2'b11), `pwr_on` in bit 1 (default 1) and `run` in bit 0 (default 1). Bits 7:4 read 0, so the default reads 8'h0F.
- R9: Register 1 holds `speed` in bits 4:3 (default 2'b11), `deemph` in bits 2:1 (default 2'b01) and `gain` in bit 0 (default 1). Bits 7:5 read 0, so the default reads 8'h1B.
- R10: Register 2 holds `inv_l` in bit 4, `inv_r` in bit 3, the wire-mode bit `wire3` in bit 2 and `in_sel` in bit 0, all with default 0. Bits 7:5 and bit 1 read 0.
- R11: A write frame changes nothing while `pwr_dn` is 1 or `mclk_ok` is 0.
- R12: While `pwr_dn` is 1, every register is held at its default from the next `clk` edge on, and `sdo_oe` is 0. Writing 0 to `run` changes only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: restores defaults and blocks writes |
| mclk_ok | input | 1 | High while the master clock is present |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Driver enable for the data-out pad |
| fmt | output | 2 | Audio interface format field |
| pwr_on | output | 1 | Power control bit |
| run | output | 1 | Soft reset bit, 0 holds internal timing in reset |
| speed | output | 2 | Sampling speed select |
| deemph | output | 2 | De-emphasis select |
| gain | output | 1 | Output scale select |
| inv_l | output | 1 | Left channel inversion |
| inv_r | output | 1 | Right channel inversion |
| wire3 | output | 1 | Write-only three-pin mode |
| in_sel | output | 1 | Serial audio input select |

## Verification
The hardest cases to reach from the ports are a frame cut off by chip select and a frame that runs past 16 clocks. Either one must leave every register untouched, or apply only the first 16 bits, while the counter and the read driver return cleanly to idle. The stimulus reaches both by driving frames of 10 and of 20 serial clocks. A behavioural model of the frame, written in the bench, predicts the registers and `sdo`/`sdo_oe` on every `clk` cycle, and these runs are compared against it. The stimulus then switches to write-only mode through the port itself and checks that a read attempt leaves the pad undriven. It also uses that mode to switch the port back.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;
   localparam int REG_W      = 8;
   localparam int ADDR_W     = 5;
   localparam int CHIP_W     = 2;
   localparam int NUM_REGS   = 3;
   localparam int FRAME_BITS = 16;
   localparam int HDR_BITS   = CHIP_W + 1 + ADDR_W;

   // value after reset or power-down
   function automatic logic [REG_W-1:0] reg_default(input int idx);
      case (idx)
         0:       return 8'h0F;
         1:       return 8'h1B;
         default: return 8'h00;
      endcase
   endfunction

   // implemented bits; others read zero
   function automatic logic [REG_W-1:0] reg_mask(input int idx);
      case (idx)
         0:       return 8'h0F;
         1:       return 8'h1F;
         default: return 8'h1D;
      endcase
   endfunction

   function automatic logic [NUM_REGS*REG_W-1:0] all_defaults();
      logic [NUM_REGS*REG_W-1:0] v;
      v = '0;
      for (int i = 0; i < NUM_REGS; i++) v[i*REG_W +: REG_W] = reg_default(i);
      return v;
   endfunction
endpackage

// File: rtl/scr_sync.sv
`timescale 1ns/1ps
module scr_sync #(
   parameter int             N_SIG   = 3,
   parameter int             STAGES  = 2,
   parameter logic [N_SIG-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] d_in,
   output logic [N_SIG-1:0] lvl
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scr_sync: STAGES must be at least 2");
      end
      if (N_SIG < 1) begin : g_bad_width
         $error("scr_sync: N_SIG must be at least 1");
      end
   endgenerate

   for (genvar s = 0; s < N_SIG; s++) begin : g_sig
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[s]}};
         else        chain <= {chain[STAGES-2:0], d_in[s]};
      end
      assign lvl[s] = chain[STAGES-1];
   end
endmodule

// File: rtl/scr_frame.sv
`timescale 1ns/1ps
module scr_frame
   import scr_pkg::*;
#(
   parameter logic [CHIP_W-1:0] CHIP_ID = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              mclk_ok,
   input  logic              cs_lvl,
   input  logic              sck_lvl,
   input  logic              sdi_lvl,
   input  logic              wire3,
   input  logic [REG_W-1:0]  rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [REG_W-1:0]  wr_data,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

   generate
      if (FRAME_BITS != HDR_BITS + REG_W) begin : g_bad_frame
         $error("scr_frame: frame length does not match its fields");
      end
   endgenerate

   logic                  sck_prev;
   logic                  sck_rise, sck_fall;
   logic [CNT_W-1:0]      cnt;
   logic [FRAME_BITS-2:0] shreg;
   logic [FRAME_BITS-1:0] full_w;
   logic [REG_W-1:0]      out_sh;
   logic                  rd_go;

   assign sck_rise = sck_lvl & ~sck_prev;
   assign sck_fall = ~sck_lvl & sck_prev;
   assign full_w   = {shreg, sdi_lvl};

   // header fields are complete once HDR_BITS bits are in
   assign rd_addr = shreg[ADDR_W-1:0];
   assign rd_go   = sck_fall && (cnt == CNT_HDR) && !sdo_oe && !wire3
                    && (shreg[HDR_BITS-1 -: CHIP_W] == CHIP_ID) && !shreg[ADDR_W];

   // the last data bit arrives with the 16th rising edge
   assign wr_addr = full_w[REG_W +: ADDR_W];
   assign wr_data = full_w[REG_W-1:0];
   assign wr_en   = sck_rise && (cnt == CNT_LAST) && !cs_lvl && !pwr_dn && mclk_ok
                    && (full_w[FRAME_BITS-1 -: CHIP_W] == CHIP_ID)
                    && full_w[REG_W+ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         shreg  <= '0;
         out_sh <= '0;
         sdo_oe <= 1'b0;
      end else if (pwr_dn || cs_lvl) begin
         cnt    <= '0;
         out_sh <= '0;
         sdo_oe <= 1'b0;
      end else begin
         if (sck_rise && (cnt < CNT_FULL)) begin
            shreg <= full_w[FRAME_BITS-2:0];
            cnt   <= cnt + CNT_W'(1);
         end
         if (rd_go) begin
            sdo_oe <= 1'b1;
            out_sh <= rd_data;
         end else if (sck_fall && sdo_oe) begin
            out_sh <= {out_sh[REG_W-2:0], 1'b0};
         end
      end
   end

   assign sdo = sdo_oe & out_sh[REG_W-1];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL); // R4
   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> (cnt == '0)); // R4
   AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> !sdo_oe); // R5
   AST_NO_DRIVE_3W: assert property (@(posedge clk) disable iff (!rst_n)
      wire3 |-> !sdo_oe); // R6
   AST_READ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(sck_fall)); // R3
endmodule

// File: rtl/scr_regs.sv
`timescale 1ns/1ps
module scr_regs
   import scr_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pwr_dn,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [REG_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [REG_W-1:0]          rd_data,
   output logic [NUM_REGS*REG_W-1:0] regs_flat
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [REG_W-1:0] DEF  = reg_default(i);
      localparam logic [REG_W-1:0] MASK = reg_mask(i);
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= DEF;
         else if (pwr_dn)                              q <= DEF;
         else if (wr_en && (wr_addr == ADDR_W'(i)))    q <= wr_data & MASK;
      end
      assign regs_flat[i*REG_W +: REG_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*REG_W +: REG_W];
   end
endmodule

// File: rtl/ctl_serial_port.sv
`timescale 1ns/1ps
module ctl_serial_port
   import scr_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [CHIP_W-1:0] CHIP_ID     = 2'b01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_dn,
   input  logic       mclk_ok,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdi,
   output logic       sdo,
   output logic       sdo_oe,
   output logic [1:0] fmt,
   output logic       pwr_on,
   output logic       run,
   output logic [1:0] speed,
   output logic [1:0] deemph,
   output logic       gain,
   output logic       inv_l,
   output logic       inv_r,
   output logic       wire3,
   output logic       in_sel
);
   localparam int R0 = 0 * REG_W;
   localparam int R1 = 1 * REG_W;
   localparam int R2 = 2 * REG_W;
   localparam logic [NUM_REGS*REG_W-1:0] DEF_FLAT = all_defaults();

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ctl_serial_port: SYNC_STAGES must be at least 2");
      end
      if (NUM_REGS != 3) begin : g_bad_regs
         $error("ctl_serial_port: field map expects three registers");
      end
   endgenerate

   logic [2:0]                  pin_lvl;
   logic [ADDR_W-1:0]           rd_addr, wr_addr;
   logic [REG_W-1:0]            rd_data, wr_data;
   logic                        wr_en;
   logic [NUM_REGS*REG_W-1:0]   regs_flat;

   // bit 2 is chip select, which idles high
   scr_sync #(.N_SIG(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({cs_n, sclk, sdi}),
      .lvl   (pin_lvl)
   );

   scr_frame #(.CHIP_ID(CHIP_ID)) i_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_dn  (pwr_dn),
      .mclk_ok (mclk_ok),
      .cs_lvl  (pin_lvl[2]),
      .sck_lvl (pin_lvl[1]),
      .sdi_lvl (pin_lvl[0]),
      .wire3   (wire3),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   scr_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_dn    (pwr_dn),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .regs_flat (regs_flat)
   );

   assign fmt    = regs_flat[R0+3 -: 2];
   assign pwr_on = regs_flat[R0+1];
   assign run    = regs_flat[R0+0];
   assign speed  = regs_flat[R1+4 -: 2];
   assign deemph = regs_flat[R1+2 -: 2];
   assign gain   = regs_flat[R1+0];
   assign inv_l  = regs_flat[R2+4];
   assign inv_r  = regs_flat[R2+3];
   assign wire3  = regs_flat[R2+2];
   assign in_sel = regs_flat[R2+0];

   AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mclk_ok && !pwr_dn) |=> $stable(regs_flat)); // R11
   AST_PD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (regs_flat == DEF_FLAT)); // R12
   AST_PD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> !sdo_oe); // R12
   AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo); // R5
endmodule

// File: tb/test_ctl_serial_port.sv
`timescale 1ns/1ps
module test_ctl_serial_port;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, pwr_dn = 1'b0, mclk_ok = 1'b1;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe, pwr_on, run, gain, inv_l, inv_r, wire3, in_sel;
   logic [1:0] fmt, speed, deemph;

   ctl_serial_port i_ctl_serial_port (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .mclk_ok(mclk_ok),
      .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .fmt(fmt), .pwr_on(pwr_on), .run(run), .speed(speed), .deemph(deemph),
      .gain(gain), .inv_l(inv_l), .inv_r(inv_r), .wire3(wire3), .in_sel(in_sel)
   );

   int checks = 0, errors = 0;
   bit cmp_en = 0;

   // reference model state
   logic [7:0]  m_reg [3];
   int          m_cnt = 0;
   logic [15:0] m_frm = '0;
   logic        m_oe = 1'b0, m_cs = 1'b1, m_pd = 1'b0, m_mck = 1'b1;
   logic [7:0]  m_out = '0;

   function automatic logic [7:0] def_of(input int i);
      return (i == 0) ? 8'h0F : (i == 1) ? 8'h1B : 8'h00;
   endfunction
   function automatic logic [7:0] mask_of(input int i);
      return (i == 0) ? 8'h0F : (i == 1) ? 8'h1F : 8'h1D;
   endfunction
   function automatic logic [7:0] m_read(input logic [4:0] a);
      return (a < 5'd3) ? m_reg[a] : 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic void m_defaults();
      for (int i = 0; i < 3; i++) m_reg[i] = def_of(i);
   endfunction
   function automatic void m_rise(input logic b);
      if (!m_cs && !m_pd && m_cnt < 16) begin
         m_frm = {m_frm[14:0], b};
         m_cnt++;
         if (m_cnt == 16 && m_frm[15:14] == 2'b01 && m_frm[13] && m_mck && m_frm[12:8] < 5'd3)
            m_reg[m_frm[12:8]] = m_frm[7:0] & mask_of(int'(m_frm[12:8]));
      end
   endfunction
   function automatic void m_fall();
      if (!m_cs && !m_pd) begin
         if (m_cnt == 8 && !m_oe && m_frm[7:6] == 2'b01 && !m_frm[5] && !m_reg[2][2]) begin
            m_oe  = 1'b1;
            m_out = m_read(m_frm[4:0]);
         end else if (m_oe) begin
            m_out = {m_out[6:0], 1'b0};
         end
      end
   endfunction
   function automatic void m_csev(input logic v);
      m_cs = v;
      if (v) begin m_cnt = 0; m_oe = 1'b0; m_out = '0; end
   endfunction

   // every-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (cmp_en) begin
         chk("R8 reg0 fields",  {4'h0, fmt, pwr_on, run}, m_reg[0]);
         chk("R9 reg1 fields",  {3'h0, speed, deemph, gain}, m_reg[1]);
         chk("R10 reg2 fields", {3'h0, inv_l, inv_r, wire3, 1'b0, in_sel}, m_reg[2]);
         chk("R5 sdo_oe", {7'h0, sdo_oe}, {7'h0, m_oe});
         chk("R3 sdo",    {7'h0, sdo},    {7'h0, m_oe & m_out[7]});
      end
   end

   task automatic drv_cs(input logic v);
      @(negedge clk); cs_n = v; #11; m_csev(v);
   endtask
   task automatic drv_pd(input logic v);
      @(negedge clk); pwr_dn = v; m_pd = v;
      if (v) begin m_defaults(); m_cnt = 0; m_oe = 1'b0; m_out = '0; end
      repeat (2) @(negedge clk);
   endtask
   task automatic drv_mck(input logic v);
      @(negedge clk); mclk_ok = v; m_mck = v;
   endtask
   task automatic drv_bit(input logic b, output logic so, output logic soe);
      @(negedge clk);
      if (sclk) begin sclk = 1'b0; sdi = b; #11; m_fall(); end
      else sdi = b;
      repeat (7) @(negedge clk);
      so = sdo; soe = sdo_oe;
      sclk = 1'b1; #11; m_rise(b);
      repeat (7) @(negedge clk);
   endtask
   task automatic frame(input logic [1:0] chip, input logic rw, input logic [4:0] addr,
                        input logic [7:0] data, input int nbits,
                        output logic [7:0] rd, output logic oe_any);
      logic [15:0] w;
      logic so, soe;
      w = {chip, rw, addr, data};
      rd = '0; oe_any = 1'b0;
      drv_cs(1'b0);
      repeat (3) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         drv_bit((i < 16) ? w[15-i] : 1'b0, so, soe);
         if (i >= 8 && i < 16) begin rd = {rd[6:0], so}; oe_any = oe_any | soe; end
      end
      @(negedge clk);
      if (sclk) begin sclk = 1'b0; #11; m_fall(); end
      repeat (3) @(negedge clk);
      drv_cs(1'b1);
      repeat (4) @(negedge clk);
   endtask
   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      logic [7:0] r; logic o;
      frame(2'b01, 1'b1, a, d, 16, r, o);
   endtask
   task automatic rd(input logic [4:0] a, output logic [7:0] r, output logic o);
      frame(2'b01, 1'b0, a, 8'h00, 16, r, o);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog act=running exp=done");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      logic o;
      m_defaults();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      cmp_en = 1;
      // reset state
      chk("R8 default",  {4'h0, fmt, pwr_on, run}, 8'h0F);
      chk("R9 default",  {3'h0, speed, deemph, gain}, 8'h1B);
      chk("R10 default", {3'h0, inv_l, inv_r, wire3, 1'b0, in_sel}, 8'h00);
      chk("R5 idle oe", {7'h0, sdo_oe}, 8'h00);
      // reads of defaults
      rd(5'd0, r, o); chk("R2 read reg0", r, 8'h0F); chk("R3 read drives", {7'h0, o}, 8'h01);
      rd(5'd1, r, o); chk("R9 read reg1", r, 8'h1B);
      rd(5'd2, r, o); chk("R10 read reg2", r, 8'h00);
      chk("R5 oe off after cs", {7'h0, sdo_oe}, 8'h00);
      // writes with masking
      wr(5'd0, 8'hA6); chk("R8 fmt", {6'h0, fmt}, 8'h01); chk("R8 run", {7'h0, run}, 8'h00);
      rd(5'd0, r, o); chk("R8 readback", r, 8'h06);
      wr(5'd1, 8'hE4); chk("R9 deemph", {6'h0, deemph}, 8'h02); chk("R9 speed", {6'h0, speed}, 8'h00);
      rd(5'd1, r, o); chk("R9 readback", r, 8'h04);
      wr(5'd2, 8'hFB); chk("R10 inv/sel", {3'h0, inv_l, inv_r, wire3, 1'b0, in_sel}, 8'h19);
      rd(5'd2, r, o); chk("R10 readback", r, 8'h19);
      // wrong chip address
      frame(2'b10, 1'b1, 5'd0, 8'hFF, 16, r, o); chk("R1 bad chip write", {4'h0, fmt, pwr_on, run}, 8'h06);
      frame(2'b11, 1'b0, 5'd1, 8'h00, 16, r, o); chk("R1 bad chip read oe", {7'h0, o}, 8'h00);
      frame(2'b00, 1'b1, 5'd1, 8'h1F, 16, r, o); chk("R1 chip 00 write", {3'h0, speed, deemph, gain}, 8'h04);
      // unimplemented addresses
      wr(5'd5, 8'hFF); chk("R7 addr5 reg0", {4'h0, fmt, pwr_on, run}, 8'h06);
      chk("R7 addr5 reg2", {3'h0, inv_l, inv_r, wire3, 1'b0, in_sel}, 8'h19);
      rd(5'h1F, r, o); chk("R7 read 1F", r, 8'h00); chk("R7 read 1F oe", {7'h0, o}, 8'h01);
      // aborted and overlong frames
      frame(2'b01, 1'b1, 5'd0, 8'h0F, 10, r, o); chk("R4 abort", {4'h0, fmt, pwr_on, run}, 8'h06);
      frame(2'b01, 1'b1, 5'd0, 8'h09, 20, r, o); chk("R4 overlong", {4'h0, fmt, pwr_on, run}, 8'h09);
      // soft reset bit only
      wr(5'd0, 8'h0E); chk("R12 run cleared", {4'h0, fmt, pwr_on, run}, 8'h0E);
      chk("R12 reg1 kept", {3'h0, speed, deemph, gain}, 8'h04);
      // blocked writes
      drv_mck(1'b0); wr(5'd1, 8'h1F); chk("R11 no mclk", {3'h0, speed, deemph, gain}, 8'h04);
      drv_mck(1'b1);
      drv_pd(1'b1);
      chk("R12 pd reg0", {4'h0, fmt, pwr_on, run}, 8'h0F);
      chk("R12 pd reg2", {3'h0, inv_l, inv_r, wire3, 1'b0, in_sel}, 8'h00);
      wr(5'd2, 8'h10); chk("R11 pd write", {3'h0, inv_l, inv_r, wire3, 1'b0, in_sel}, 8'h00);
      drv_pd(1'b0);
      // write-only mode
      wr(5'd2, 8'h04); chk("R10 wire3 set", {7'h0, wire3}, 8'h01);
      rd(5'd0, r, o); chk("R6 no drive", {7'h0, o}, 8'h00); chk("R6 no data", r, 8'h00);
      wr(5'd0, 8'h03); chk("R6 write in 3w", {4'h0, fmt, pwr_on, run}, 8'h03);
      wr(5'd2, 8'h00);
      rd(5'd0, r, o); chk("R5 back to 4w", r, 8'h03); chk("R5 drive again", {7'h0, o}, 8'h01);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule